// File: doc/BRIEF.md
# Single-CPU Interrupt Controller with Acknowledge and End-of-Interrupt

This block collects a vector of interrupt request lines and tracks each source through a four-state lifecycle: idle, pending, active, and active-with-a-new-request. Each line can be sampled as a level or as a rising edge. Every source has a programmable priority. An arbiter picks the best pending source. A CPU-side gate then compares that candidate with a CPU priority threshold. The interrupt output is raised only when the candidate passes.

The CPU works through a simple register port with valid, write, address and data signals. Read data is combinational in the cycle of the access. Reading the acknowledge register returns the winning source ID and claims that source. Writing a source ID to the end-of-interrupt register retires it. The reserved ID 1023 signals that no source was eligible. Requests are never counted: a source that is already waiting absorbs any further request.

Register map (8-bit address):
- 0x00: threshold (R/W, PRIO_W+1 bits).
- 0x01: acknowledge (R).
- 0x02: end-of-interrupt (W).
- 0x03: edge-select vector (R/W, bit n set means source n is edge-triggered).
- 0x40+n: priority of source n (R/W).
- 0x80+n: lifecycle state of source n (R).

Top module: `irqc_top`

## Requirements
- R1: After reset, every source is idle (state code 0), every priority reads 0, the threshold reads 0, the edge-select vector reads 0, and irqOut is low.
- R2: The state codes are idle=0, pending=1, active=2 and active-and-pending=3. A level source moves from idle to pending on any clock edge where its line is high. An edge source moves only on an edge where its line is high and was low at the previous edge; a line held high does not request again.
- R3: Among sources in state pending (code 1), the selected candidate has the lowest priority value, and ties go to the lowest source number.
- R4: irqOut is high exactly when a candidate exists and its priority value is strictly less than the threshold.
- R5: A read of 0x01 while irqOut is high returns the candidate's source number in that cycle, and the source becomes active (code 2) at that clock edge.
- R6: A read of 0x01 while irqOut is low returns 1023 and changes no source state.
- R7: A request seen by an active source moves it to active-and-pending (code 3).
- R8: Writing a source number to 0x02 moves active to idle and active-and-pending to pending. A write naming a source that is idle or pending, an out-of-range value, or a value with any upper bits set changes nothing.
- R9: Extra requests are absorbed: any number of requests while pending or active-and-pending leave exactly one pending instance, so one acknowledge and one end-of-interrupt return the source to idle.
- R10: The priority and threshold registers read back the values written. The lifecycle state of source n reads at 0x80+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | NUM_SRC | Interrupt request lines, one per source |
| regValid | input | 1 | Register access strobe, one cycle per access |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Register address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid in the cycle of a read |
| irqOut | output | 1 | Interrupt request to the CPU |

## Verification
A corrupted lifecycle state shows up at the ports within one access. A source stuck pending, or wrongly pending, changes irqOut or the next acknowledge ID at once. A source stuck active makes its end-of-interrupt leave the wrong code in the state readback on the following read. Arbitration faults are exposed by draining a full set of pending sources with mixed priorities: each acknowledge in that drain must match the bench's computed winner. Threshold faults are exposed by sweeping every priority value against every threshold value and checking irqOut and the spurious ID.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ID_W = 10;
  localparam int REG_ADDR_W = 8;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2,
    ST_BOTH = 2'd3
  } srcState_t;

  typedef struct packed {
    logic ackRd;
    logic eoiWr;
    logic maskWe;
    logic edgeWe;
    logic prioWe;
    logic rdMask;
    logic rdEdge;
    logic rdPrio;
    logic rdState;
  } regStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic                  regValid,
  input  logic                  regWrite,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output regStrobe_t            stb
);
  always_comb begin
    stb = '0;
    if (regValid) begin
      unique case (regAddr[7:6])
        2'b00: begin
          case (regAddr[5:0])
            6'd0: begin
              stb.maskWe = regWrite;
              stb.rdMask = !regWrite;
            end
            6'd1: stb.ackRd = !regWrite;
            6'd2: stb.eoiWr = regWrite;
            6'd3: begin
              stb.edgeWe = regWrite;
              stb.rdEdge = !regWrite;
            end
            default: ;
          endcase
        end
        2'b01: begin
          stb.prioWe = regWrite;
          stb.rdPrio = !regWrite;
        end
        2'b10: stb.rdState = !regWrite;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  regStrobe_t         stb,
  input  logic [5:0]         srcSel,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqOut
);
  localparam int IDX_W = $clog2(NUM_SRC);

  srcState_t            srcState [NUM_SRC];
  srcState_t            stateNxt [NUM_SRC];
  logic [PRIO_W-1:0]    prio     [NUM_SRC];
  logic [NUM_SRC-1:0]   edgeMode;
  logic [NUM_SRC-1:0]   lineQ;
  logic [PRIO_W:0]      mask;

  logic [NUM_SRC-1:0]   reqEvent;
  logic [NUM_SRC-1:0]   actVec;
  logic                 candValid;
  logic [IDX_W-1:0]     candIdx;
  logic [PRIO_W-1:0]    candPrio;
  logic                 eligible;
  logic                 selOk;
  logic [IDX_W-1:0]     selIdx;

  assign selOk  = {1'b0, srcSel} < 7'(NUM_SRC);
  assign selIdx = srcSel[IDX_W-1:0];

  // Request events: level sources follow the line, edge sources need a 0->1 step
  assign reqEvent = (edgeMode & irqLines & ~lineQ) | (~edgeMode & irqLines);

  // Arbiter over pending sources; strict compare keeps the lowest number on ties
  always_comb begin
    candValid = 1'b0;
    candIdx   = '0;
    candPrio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcState[i] == ST_PEND && (!candValid || prio[i] < candPrio)) begin
        candValid = 1'b1;
        candIdx   = IDX_W'(i);
        candPrio  = prio[i];
      end
    end
  end

  // CPU-side gate
  assign eligible = candValid && ({1'b0, candPrio} < mask);
  assign irqOut   = eligible;

  // Lifecycle: apply acknowledge / end-of-interrupt first, then the request
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      stateNxt[i] = srcState[i];
      if (stb.ackRd && eligible && candIdx == IDX_W'(i))
        stateNxt[i] = ST_ACT;
      if (stb.eoiWr && regWdata == DATA_W'(i)) begin
        if (srcState[i] == ST_ACT)  stateNxt[i] = ST_IDLE;
        if (srcState[i] == ST_BOTH) stateNxt[i] = ST_PEND;
      end
      if (reqEvent[i]) begin
        if (stateNxt[i] == ST_IDLE) stateNxt[i] = ST_PEND;
        else if (stateNxt[i] == ST_ACT) stateNxt[i] = ST_BOTH;
      end
      actVec[i] = (srcState[i] == ST_ACT) || (srcState[i] == ST_BOTH);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        srcState[i] <= ST_IDLE;
        prio[i]     <= '0;
      end
      edgeMode <= '0;
      lineQ    <= '0;
      mask     <= '0;
    end else begin
      srcState <= stateNxt;
      lineQ    <= irqLines;
      if (stb.maskWe) mask <= regWdata[PRIO_W:0];
      if (stb.edgeWe) edgeMode <= regWdata[NUM_SRC-1:0];
      if (stb.prioWe && selOk) prio[selIdx] <= regWdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (stb.rdMask)
      regRdata = DATA_W'(mask);
    else if (stb.ackRd)
      regRdata = eligible ? DATA_W'(candIdx) : DATA_W'(SPURIOUS_ID);
    else if (stb.rdEdge)
      regRdata = DATA_W'(edgeMode);
    else if (stb.rdPrio && selOk)
      regRdata = DATA_W'(prio[selIdx]);
    else if (stb.rdState && selOk)
      regRdata = DATA_W'(srcState[selIdx]);
  end

  // ---------------- assertions ----------------
  // R3: the arbiter only ever names a source whose state register says pending
  a_r3_cand_pending: assert property (@(posedge clk) disable iff (!rstN)
    candValid |-> srcState[candIdx] == ST_PEND);

  // R4: the output never rises for a candidate at or above the threshold
  a_r4_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ({1'b0, prio[candIdx]} < mask));

  // R5: an accepted acknowledge leaves that source claimed
  a_r5_ack_claims: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackRd && irqOut) |=> actVec[$past(candIdx)]);

  // R6: a spurious acknowledge claims nothing
  a_r6_spurious_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackRd && !irqOut) |=> $countones(actVec) == $past($countones(actVec)));

  // R8: a completed source is no longer claimed
  a_r8_eoi_releases: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoiWr && regWdata < DATA_W'(NUM_SRC) && actVec[regWdata[IDX_W-1:0]])
      |=> !actVec[$past(regWdata[IDX_W-1:0])]);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_chk
    // R2: an idle source can only stay idle or become pending
    a_r2_idle_step: assert property (@(posedge clk) disable iff (!rstN)
      (srcState[g] == ST_IDLE) |=> (srcState[g] == ST_IDLE || srcState[g] == ST_PEND));
    // R9: active-and-pending only leaves through end-of-interrupt
    a_r9_both_holds: assert property (@(posedge clk) disable iff (!rstN)
      (srcState[g] == ST_BOTH && !(stb.eoiWr && regWdata == DATA_W'(g)))
        |=> srcState[g] == ST_BOTH);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    irqLines,
  input  logic                  regValid,
  input  logic                  regWrite,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  output logic                  irqOut
);
  regStrobe_t stb;

  irqc_ctrl u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .stb      (stb)
  );

  irqc_datapath #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (irqLines),
    .stb      (stb),
    .srcSel   (regAddr[5:0]),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  localparam int N = 32;
  localparam logic [7:0] A_MASK = 8'h00, A_ACK = 8'h01, A_EOI = 8'h02, A_EDGE = 8'h03;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [N-1:0] lines = '0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int total = 0, fails = 0;
  int expSt [N];
  int expPr [N];

  always #2.5 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rstN(rstN), .irqLines(lines), .regValid(regValid),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = int'(regRdata);
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); lines[i] = 1'b1;
    @(negedge clk); lines[i] = 1'b0;
  endtask

  task automatic chkState(input string req, input int i, input int exp);
    int d;
    rd(8'h80 + 8'(i), d);
    chk(req, d, exp);
  endtask

  task automatic chkAck(input string req, input int exp);
    int d;
    rd(A_ACK, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    #1 chk("R1 irqOut", int'(irqOut), 0);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_EDGE, d); chk("R1 edge", d, 0);
    for (int i = 0; i < N; i++) begin
      chkState("R1 state", i, 0);
      rd(8'h40 + 8'(i), d); chk("R1 prio", d, 0);
    end
    chkAck("R6 empty ack", 1023);

    // R2 R4 R5 R8 R10: per-source sweep, level mode
    wr(A_MASK, 16);
    rd(A_MASK, d); chk("R10 mask readback", d, 16);
    for (int i = 0; i < N; i++) begin
      expPr[i] = 15 - (i % 16);
      wr(8'h40 + 8'(i), 32'(expPr[i]));
      rd(8'h40 + 8'(i), d); chk("R10 prio readback", d, expPr[i]);
      pulse(i);
      chkState("R2 level pend", i, 1);
      #1 chk("R4 irq raised", int'(irqOut), 1);
      chkAck("R5 ack id", i);
      chkState("R5 active", i, 2);
      #1 chk("R4 irq dropped", int'(irqOut), 0);
      wr(A_EOI, 32'(i));
      chkState("R8 eoi idle", i, 0);
    end

    // R7 R9: absorb extra requests on source 5
    pulse(5); pulse(5);
    chkState("R9 pend absorbs", 5, 1);
    chkAck("R5 ack 5", 5);
    pulse(5);
    chkState("R7 active to both", 5, 3);
    pulse(5);
    chkState("R9 both absorbs", 5, 3);
    wr(A_EOI, 5);
    chkState("R8 both to pend", 5, 1);
    chkAck("R9 single reissue", 5);
    wr(A_EOI, 5);
    chkState("R9 back idle", 5, 0);
    chkAck("R6 spurious after drain", 1023);

    // R2: edge source 7 versus level source 8, both held high
    wr(8'h47, 2); wr(8'h48, 3);
    wr(A_EDGE, 32'h80);
    rd(A_EDGE, d); chk("R10 edge readback", d, 32'h80);
    @(negedge clk); lines[7] = 1'b1; lines[8] = 1'b1;
    chkState("R2 edge pend", 7, 1);
    chkState("R2 level pend held", 8, 1);
    chkAck("R3 prio 2 wins", 7);
    chkState("R2 edge held no repend", 7, 2);
    chkAck("R5 ack 8", 8);
    chkState("R2 level held repends", 8, 3);
    @(negedge clk); lines[7] = 1'b0; lines[8] = 1'b0;
    chkState("R2 edge still active", 7, 2);
    pulse(7);
    chkState("R7 edge rise on active", 7, 3);
    wr(A_EOI, 8); chkState("R8 eoi 8", 8, 1);
    chkAck("R5 ack 8 again", 8);
    wr(A_EOI, 8); chkState("R8 eoi 8 idle", 8, 0);
    wr(A_EOI, 7); chkState("R8 eoi 7", 7, 1);
    chkAck("R5 ack 7 again", 7);
    wr(A_EOI, 7); chkState("R8 eoi 7 idle", 7, 0);
    wr(A_EDGE, 0);

    // R8: ignored end-of-interrupt writes
    pulse(10);
    wr(A_EOI, 10); chkState("R8 eoi on pending ignored", 10, 1);
    chkAck("R5 ack 10", 10);
    wr(A_EOI, 32'h400 | 32'd10); chkState("R8 upper bits ignored", 10, 2);
    wr(A_EOI, 1023); chkState("R8 reserved id ignored", 10, 2);
    wr(A_EOI, 11);
    chkState("R8 idle target unchanged", 11, 0);
    chkState("R8 other active unchanged", 10, 2);
    wr(A_EOI, 10); chkState("R8 eoi 10", 10, 0);

    // R3: drain all sources with mixed priorities
    for (int i = 0; i < N; i++) begin
      expPr[i] = (i * 11 + 3) % 16;
      wr(8'h40 + 8'(i), 32'(expPr[i]));
      expSt[i] = 1;
    end
    @(negedge clk); lines = '1;
    @(negedge clk); lines = '0;
    for (int k = 0; k < N; k++) begin
      int best;
      best = -1;
      for (int i = 0; i < N; i++)
        if (expSt[i] == 1 && (best < 0 || expPr[i] < expPr[best])) best = i;
      chkAck("R3 arbitration order", best);
      wr(A_EOI, 32'(best));
      expSt[best] = 0;
    end
    chkAck("R6 drained", 1023);

    // R4 R6: every priority against every threshold on source 9
    for (int p = 0; p < 16; p++) begin
      wr(8'h49, 32'(p));
      pulse(9);
      for (int m = 0; m <= 16; m++) begin
        wr(A_MASK, 32'(m));
        #1 chk("R4 threshold gate", int'(irqOut), (p < m) ? 1 : 0);
        if (!(p < m)) begin
          chkAck("R6 masked ack", 1023);
          chkState("R6 no state change", 9, 1);
        end
      end
      chkAck("R5 unmasked ack", 9);
      wr(A_EOI, 9);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule